// File: doc/BRIEF.md
# Capture-Only Boundary Test Port

This block is the serial test port of a memory device. A four-pin serial interface (clock, mode select, data in, data out) walks a sixteen-state controller. The controller chooses between an instruction register and one of three data registers: a single bypass bit, a fixed 32-bit identification word, and a 69-bit boundary register. Board test equipment uses the port to identify the device, to skip it in a long chain, or to take a snapshot of the levels on every pin of the package.

The boundary register only observes. Every instruction that uses it, including the ones that would drive pins on a fully compliant port, captures the pin ring and shifts the snapshot out. Nothing is ever driven or preloaded onto the pins. One instruction also raises a flag that tells the memory to put its data outputs into high impedance. The data-out pin is supplied as a value plus an enable, and the pad that combines them sits outside this block.

A controller reset, by power-on reset or by five rising clock edges with the mode pin high, only touches test logic. It leaves the memory's own operation alone.

Top module: `scan_port`

## Requirements
- R1: `tdi` and `tms` are sampled on the rising edge of `tck`. `tdo` and `tdo_oe` change only on the falling edge of `tck`.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. This makes `tdo_oe` low and makes IDCODE the active instruction.
- R3: After `por_n` is released, `tdo_oe` is low, `outputs_hiz` is low and IDCODE is active. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R4: Instruction codes are: 000 EXTEST, 001 IDCODE, 010 SAMPLE Z, 100 SAMPLE/PRELOAD, 111 BYPASS. The reserved codes 011, 101 and 110 select the bypass register.
- R5: The instruction register is 3 bits and shifts LSB first toward `tdo`. In Capture-IR it loads binary 001: the two low bits take 01 and the top bit takes 0.
- R6: A shifted instruction becomes active only on the rising edge that leaves Update-IR. Entering Test-Logic-Reset loads IDCODE.
- R7: Under IDCODE, Capture-DR loads the 32-bit identification word `ID_WORD`, with bit 0 forced to 1. The word shifts out LSB first.
- R8: Under BYPASS or a reserved code, the one-bit bypass register captures 0 in Capture-DR and delays `tdi` by one shift.
- R9: Under EXTEST, SAMPLE/PRELOAD and SAMPLE Z, Capture-DR loads `ring_pins` into the 69-bit boundary register. Bit 0 leaves first on `tdo`, and `tdi` enters at bit 68, so the bit shifted in first reaches `tdo` after 69 shifts.
- R10: `outputs_hiz` is high exactly while SAMPLE Z is the active instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| ring_pins | input | BSR_LEN | Live levels of the package pin ring, sampled on capture |
| tdo | output | 1 | Serial data out, valid when `tdo_oe` is high |
| tdo_oe | output | 1 | Enable for the external `tdo` pad driver |
| outputs_hiz | output | 1 | Asks the memory to float its data outputs |

## Verification
The assertions assume the following about the inputs:
- `tck` runs freely.
- `por_n` is held low from time zero until after the first edges.
- `tms` and `tdi` settle well away from the rising edge.
- `ring_pins` stays constant while a capture edge is taken.

The bench meets these assumptions by changing `tms` and `tdi` one nanosecond after each falling edge and by loading a new random ring value only between scans. Random instruction codes, random scan data and random controller walks before each five-high reset all come from the same seeded generator. Each random case therefore lands on legal, repeatable edge timing.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_DR_SEL   = 4'd2,
    ST_DR_CAP   = 4'd3,
    ST_DR_SHIFT = 4'd4,
    ST_DR_EXIT1 = 4'd5,
    ST_DR_PAUSE = 4'd6,
    ST_DR_EXIT2 = 4'd7,
    ST_DR_UPD   = 4'd8,
    ST_IR_SEL   = 4'd9,
    ST_IR_CAP   = 4'd10,
    ST_IR_SHIFT = 4'd11,
    ST_IR_EXIT1 = 4'd12,
    ST_IR_PAUSE = 4'd13,
    ST_IR_EXIT2 = 4'd14,
    ST_IR_UPD   = 4'd15
  } tap_state_e;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST  = 3'b000,
    OP_IDCODE  = 3'b001,
    OP_HIZ     = 3'b010,
    OP_RSV_A   = 3'b011,
    OP_SAMPLE  = 3'b100,
    OP_RSV_B   = 3'b101,
    OP_RSV_C   = 3'b110,
    OP_BYPASS  = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_ID  = 2'd1,
    SEL_BSR = 2'd2
  } dr_sel_e;

  function automatic tap_state_e tap_step(tap_state_e s, logic tms);
    tap_state_e n;
    case (s)
      ST_RESET:    n = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     n = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   n = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: n = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: n = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: n = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: n = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   n = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   n = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: n = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: n = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: n = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: n = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     n = tms ? ST_DR_SEL   : ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic dr_sel_e op_to_sel(op_e op);
    dr_sel_e s;
    case (op)
      OP_EXTEST, OP_HIZ, OP_SAMPLE: s = SEL_BSR;
      OP_IDCODE:                    s = SEL_ID;
      default:                      s = SEL_BYP;
    endcase
    return s;
  endfunction

  function automatic logic [31:0] id_fix(logic [31:0] raw);
    return {raw[31:1], 1'b1};
  endfunction

  function automatic logic [IR_W-1:0] ir_capture_pattern();
    logic [IR_W-1:0] p;
    p = '0;
    p[1:0] = 2'b01;
    return p;
  endfunction

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_nx,
  output logic       ev_dr_cap,
  output logic       ev_dr_shift,
  output logic       ev_ir_cap,
  output logic       ev_ir_shift,
  output logic       ev_ir_upd,
  output logic       ev_enter_reset
);

  always_comb state_nx = tap_step(state_q, tms);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state_q <= ST_RESET;
    else        state_q <= state_nx;
  end

  assign ev_dr_cap      = (state_q == ST_DR_CAP);
  assign ev_dr_shift    = (state_q == ST_DR_SHIFT);
  assign ev_ir_cap      = (state_q == ST_IR_CAP);
  assign ev_ir_shift    = (state_q == ST_IR_SHIFT);
  assign ev_ir_upd      = (state_q == ST_IR_UPD);
  assign ev_enter_reset = (state_nx == ST_RESET);

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  logic            ev_cap,
  input  logic            ev_shift,
  input  logic            ev_upd,
  input  logic            ev_enter_reset,
  output logic [IR_W-1:0] ir_shift_q,
  output op_e             ir_active_q
);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)        ir_shift_q <= '0;
    else if (ev_cap)   ir_shift_q <= ir_capture_pattern();
    else if (ev_shift) ir_shift_q <= {tdi, ir_shift_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)              ir_active_q <= OP_IDCODE;
    else if (ev_enter_reset) ir_active_q <= OP_IDCODE;
    else if (ev_upd)         ir_active_q <= op_e'(ir_shift_q);
  end

endmodule

// File: rtl/scan_port_shreg.sv
module scan_port_shreg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         por_n,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic [W-1:0] q
);

  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      assign shifted = tdi;
    end else begin : g_multi
      assign shifted = {tdi, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)        q <= '0;
    else if (cap_en)   q <= cap_val;
    else if (shift_en) q <= shifted;
  end

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_port_pkg::*;
#(
  parameter int          BSR_LEN = 69,
  parameter logic [31:0] ID_WORD = 32'h5A3C_0E97
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] ring_pins,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               outputs_hiz
);

  localparam logic [31:0] ID_VAL = id_fix(ID_WORD);

  tap_state_e      state_q;
  tap_state_e      state_nx;
  logic            ev_dr_cap;
  logic            ev_dr_shift;
  logic            ev_ir_cap;
  logic            ev_ir_shift;
  logic            ev_ir_upd;
  logic            ev_enter_reset;
  logic [IR_W-1:0] ir_shift_q;
  op_e             ir_active_q;
  dr_sel_e         dr_sel;

  logic [0:0]         byp_q;
  logic [31:0]        id_q;
  logic [BSR_LEN-1:0] bsr_q;

  logic cap_byp, cap_id, cap_bsr;
  logic sh_byp, sh_id, sh_bsr;
  logic dr_lsb;
  logic tdo_q, oe_q;

  scan_port_fsm u_fsm (
    .tck(tck), .por_n(por_n), .tms(tms),
    .state_q(state_q), .state_nx(state_nx),
    .ev_dr_cap(ev_dr_cap), .ev_dr_shift(ev_dr_shift),
    .ev_ir_cap(ev_ir_cap), .ev_ir_shift(ev_ir_shift),
    .ev_ir_upd(ev_ir_upd), .ev_enter_reset(ev_enter_reset)
  );

  scan_port_ir u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi),
    .ev_cap(ev_ir_cap), .ev_shift(ev_ir_shift), .ev_upd(ev_ir_upd),
    .ev_enter_reset(ev_enter_reset),
    .ir_shift_q(ir_shift_q), .ir_active_q(ir_active_q)
  );

  assign dr_sel  = op_to_sel(ir_active_q);
  assign cap_byp = ev_dr_cap   && (dr_sel == SEL_BYP);
  assign cap_id  = ev_dr_cap   && (dr_sel == SEL_ID);
  assign cap_bsr = ev_dr_cap   && (dr_sel == SEL_BSR);
  assign sh_byp  = ev_dr_shift && (dr_sel == SEL_BYP);
  assign sh_id   = ev_dr_shift && (dr_sel == SEL_ID);
  assign sh_bsr  = ev_dr_shift && (dr_sel == SEL_BSR);

  scan_port_shreg #(.W(1)) u_byp (
    .tck(tck), .por_n(por_n), .cap_en(cap_byp), .shift_en(sh_byp),
    .cap_val(1'b0), .tdi(tdi), .q(byp_q)
  );

  scan_port_shreg #(.W(32)) u_id (
    .tck(tck), .por_n(por_n), .cap_en(cap_id), .shift_en(sh_id),
    .cap_val(ID_VAL), .tdi(tdi), .q(id_q)
  );

  scan_port_shreg #(.W(BSR_LEN)) u_bsr (
    .tck(tck), .por_n(por_n), .cap_en(cap_bsr), .shift_en(sh_bsr),
    .cap_val(ring_pins), .tdi(tdi), .q(bsr_q)
  );

  always_comb begin
    case (dr_sel)
      SEL_ID:  dr_lsb = id_q[0];
      SEL_BSR: dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q[0];
    endcase
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= (state_q == ST_IR_SHIFT) ? ir_shift_q[0] : dr_lsb;
      oe_q  <= (state_q == ST_IR_SHIFT) || (state_q == ST_DR_SHIFT);
    end
  end

  assign tdo         = tdo_q;
  assign tdo_oe      = oe_q;
  assign outputs_hiz = (ir_active_q == OP_HIZ);

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int BSR_LEN = 69
) (
  input logic               tck,
  input logic               por_n,
  input logic               tms,
  input logic               tdo_oe,
  input logic               outputs_hiz,
  input logic [BSR_LEN-1:0] ring_pins,
  input tap_state_e         state_q,
  input op_e                ir_active_q,
  input logic [IR_W-1:0]    ir_shift_q,
  input dr_sel_e            dr_sel,
  input logic [0:0]         byp_q,
  input logic [31:0]        id_q,
  input logic [BSR_LEN-1:0] bsr_q
);

  logic [2:0] high_run;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)             high_run <= 3'd0;
    else if (!tms)          high_run <= 3'd0;
    else if (high_run < 3'd5) high_run <= high_run + 3'd1;
  end

  AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!por_n)
    (high_run == 3'd5) |-> (state_q == ST_RESET)) else $error("five-high reset"); // R2

  AST_OE_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state_q == ST_IR_SHIFT || state_q == ST_DR_SHIFT)) else $error("oe"); // R3

  AST_RESET_HOLDS_IDCODE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == ST_RESET) |-> (ir_active_q == OP_IDCODE)) else $error("reset op"); // R6

  AST_IR_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q != ST_IR_UPD && !tms) |=> $stable(ir_active_q)) else $error("ir update"); // R6

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == ST_IR_CAP) |=> (ir_shift_q == 3'b001)) else $error("ir capture"); // R5

  AST_ID_LSB_ONE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == ST_DR_CAP && dr_sel == SEL_ID) |=> id_q[0]) else $error("id lsb"); // R7

  AST_BYPASS_CLEARS: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == ST_DR_CAP && dr_sel == SEL_BYP) |=> (byp_q == 1'b0)) else $error("bypass"); // R8

  AST_BSR_SNAPSHOT: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == ST_DR_CAP && dr_sel == SEL_BSR) |=> (bsr_q == $past(ring_pins))) else $error("bsr"); // R9

  AST_HIZ_RISES_ON_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
    $rose(outputs_hiz) |-> ($past(state_q) == ST_IR_UPD)) else $error("hiz"); // R10

endmodule

bind scan_port scan_port_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .tdo_oe(tdo_oe),
  .outputs_hiz(outputs_hiz), .ring_pins(ring_pins),
  .state_q(state_q), .ir_active_q(ir_active_q), .ir_shift_q(ir_shift_q),
  .dr_sel(dr_sel), .byp_q(byp_q), .id_q(id_q), .bsr_q(bsr_q)
);

// File: tb/scan_port_bench.sv
`timescale 1ns/1ps
module scan_port_bench;

  localparam int          BSR_LEN = 69;
  localparam logic [31:0] ID_WORD = 32'h5A3C_0E96;
  localparam int          VW      = 160;

  logic               tck = 1'b0;
  logic               por_n = 1'b0;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic [BSR_LEN-1:0] ring = '0;
  logic               tdo, tdo_oe, outputs_hiz;

  int  n_checks = 0;
  int  n_bad    = 0;
  int  r1_bad   = 0;
  logic cur_tdo, cur_oe;

  scan_port #(.BSR_LEN(BSR_LEN), .ID_WORD(ID_WORD)) u_scan_port (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .ring_pins(ring),
    .tdo(tdo), .tdo_oe(tdo_oe), .outputs_hiz(outputs_hiz)
  );

  always #5 tck = ~tck;

  // Expected identification word: bit 0 always 1 (R7)
  function automatic logic [31:0] exp_id();
    return ID_WORD | 32'h1;
  endfunction

  // Register length per code (R4)
  function automatic int exp_len(logic [2:0] op);
    if (op == 3'b000 || op == 3'b010 || op == 3'b100) return BSR_LEN;
    if (op == 3'b001) return 32;
    return 1;
  endfunction

  function automatic logic [VW-1:0] exp_cap(logic [2:0] op, logic [BSR_LEN-1:0] pins);
    logic [VW-1:0] v;
    v = '0;
    if (exp_len(op) == BSR_LEN) v[BSR_LEN-1:0] = pins;
    else if (op == 3'b001)      v[31:0] = exp_id();
    return v;
  endfunction

  // Two-length scan: captured word, then the data shifted in
  function automatic logic [VW-1:0] exp_stream(logic [VW-1:0] cap, logic [VW-1:0] din, int len);
    logic [VW-1:0] v;
    v = '0;
    for (int i = 0; i < 2*len; i++) v[i] = (i < len) ? cap[i] : din[i-len];
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    logic pre, post;
    tms = m;
    tdi = d;
    #3 pre = tdo;
    #2 post = tdo;
    if (pre !== post) r1_bad++;
    @(negedge tck);
    #1;
    cur_tdo = tdo;
    cur_oe  = tdo_oe;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap_out);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    chk(cur_oe === 1'b1, "R3 oe in shift-ir", VW'(cur_oe), VW'(1));
    for (int i = 0; i < 3; i++) begin
      cap_out[i] = cur_tdo;
      step(i == 2, op[i]);
    end
  endtask

  task automatic finish_ir();
    step(1, 0);
    step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [VW-1:0] din, output logic [VW-1:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = cur_tdo;
      step(i == n-1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [2:0]    irc;
    logic [VW-1:0] din, dout, expv;
    int            len;
    void'($urandom(32'd2024));
    #23 por_n = 1'b1;
    @(negedge tck); #1;
    cur_tdo = tdo; cur_oe = tdo_oe;

    chk(tdo_oe === 1'b0, "R3 oe after power-up", VW'(tdo_oe), VW'(0));
    chk(outputs_hiz === 1'b0, "R3 hiz after power-up", VW'(outputs_hiz), VW'(0));
    step(0, 0);

    din = rnd_vec();
    scan_dr(64, din, dout);
    expv = exp_stream(exp_cap(3'b001, ring), din, 32);
    chk(dout[63:0] === expv[63:0], "R7 idcode after power-up", dout, expv);
    chk(cur_oe === 1'b0, "R3 oe low outside shift", VW'(cur_oe), VW'(0));

    load_ir(3'b111, irc);
    chk(irc === 3'b001, "R5 ir capture pattern", VW'(irc), VW'(3'b001));
    finish_ir();
    din = rnd_vec();
    scan_dr(16, din, dout);
    expv = {din[VW-2:0], 1'b0};
    chk(dout[15:0] === expv[15:0], "R8 bypass delay", dout, expv);

    // R6 / R10: pending SAMPLE Z not active until Update-IR is left
    load_ir(3'b010, irc);
    chk(outputs_hiz === 1'b0, "R6 no effect before update", VW'(outputs_hiz), VW'(0));
    step(1, 0);
    chk(outputs_hiz === 1'b0, "R6 no effect in update state", VW'(outputs_hiz), VW'(0));
    step(0, 0);
    chk(outputs_hiz === 1'b1, "R10 hiz after update", VW'(outputs_hiz), VW'(1));

    for (int it = 0; it < 24; it++) begin
      logic [2:0] op;
      op = (it < 8) ? it[2:0] : 3'($urandom);
      ring = BSR_LEN'(rnd_vec());
      load_ir(op, irc);
      finish_ir();
      chk(outputs_hiz === (op == 3'b010), "R10 hiz by code", VW'(outputs_hiz), VW'(op == 3'b010));
      len  = exp_len(op);
      din  = rnd_vec();
      scan_dr(2*len, din, dout);
      expv = exp_stream(exp_cap(op, ring), din, len);
      for (int b = 2*len; b < VW; b++) begin
        dout[b] = 1'b0;
        expv[b] = 1'b0;
      end
      if (len == BSR_LEN)
        chk(dout === expv, "R9 boundary snapshot and pass-through", dout, expv);
      else if (len == 32)
        chk(dout === expv, "R7 idcode stream", dout, expv);
      else
        chk(dout === expv, "R4 R8 bypass or reserved code", dout, expv);
    end

    for (int it = 0; it < 8; it++) begin
      int walk;
      load_ir((it[0] ? 3'b010 : 3'b111), irc);
      finish_ir();
      walk = $urandom_range(0, 12);
      for (int w = 0; w < walk; w++) step(1'($urandom), 1'($urandom));
      for (int w = 0; w < 5; w++) step(1, 0);
      chk(tdo_oe === 1'b0, "R2 oe low after five-high reset", VW'(tdo_oe), VW'(0));
      chk(outputs_hiz === 1'b0, "R2 idcode active after reset", VW'(outputs_hiz), VW'(0));
      step(0, 0);
      din = rnd_vec();
      scan_dr(32, din, dout);
      chk(dout[31:0] === exp_id(), "R2 R6 idcode after reset", dout, VW'(exp_id()));
    end

    chk(r1_bad == 0, "R1 tdo steady across rising edge", VW'(r1_bad), VW'(0));

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_checks++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule